// File: doc/BRIEF.md
# Conditional Branch Evaluation Unit

This unit decides control flow for the two jump instruction classes of a 64-bit register virtual machine. Each accepted instruction carries an 8-bit opcode, the destination and source register values, a 32-bit immediate, a 16-bit signed offset and the current program counter. One cycle later the unit reports whether the branch is taken, the next program counter, whether the instruction requests a helper call or a program exit, and whether the opcode is not a legal jump.

The opcode's low three bits give the class: 5 is the wide class, which compares full 64-bit operands, and 6 is the narrow class, which compares only the low 32 bits of each operand. Opcode bit 3 picks the second operand: the source register when 1, the immediate when 0. The upper nibble is the condition code. The program counter counts 64-bit instruction slots. The unit only flags calls and exits; executing them belongs to the surrounding pipeline.

Top module: `brn_eval_unit`

## Requirements
- R1: While reset is low, out_valid, br_taken, call_req, exit_req and illegal_op are 0 and next_pc is 0.
- R2: A vector presented with in_valid high appears on the outputs at the next rising edge with out_valid high; after a cycle with in_valid low, out_valid and all four flags are 0.
- R3: Class 6 compares only bits [31:0] of both operands (signed codes use bit 31 as the sign); class 5 compares all 64 bits.
- R4: Opcode bit 3 = 1 selects src_val as second operand, bit 3 = 0 selects the immediate, which is sign-extended to 64 bits in class 5.
- R5: Unsigned codes: 0x2 greater, 0x3 greater-or-equal, 0xA less, 0xB less-or-equal, taken when the relation of destination to second operand holds.
- R6: Signed codes: 0x6 greater, 0x7 greater-or-equal, 0xC less, 0xD less-or-equal, in two's complement.
- R7: Code 0x1 is taken on equality, 0x5 on inequality, 0x4 when the bitwise AND of the operands is nonzero.
- R8: Code 0x0 is always taken in class 5 and is illegal in class 6.
- R9: Code 0x8 raises call_req in either jump class, is not taken, and advances next_pc by one.
- R10: Code 0x9 raises exit_req in class 5 only, is not taken, and is illegal in class 6.
- R11: A taken branch sets next_pc to pc + 1 + sign-extended offset; otherwise next_pc is pc + 1; both wrap modulo 2^32.
- R12: Codes 0xE and 0xF, and every class other than 5 and 6, raise illegal_op with br_taken, call_req and exit_req at 0 and next_pc = pc + 1.
- R13: At most one of br_taken, call_req, exit_req and illegal_op is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction present this cycle |
| opcode | input | 8 | Condition code, source select, class |
| dst_val | input | 64 | Destination register value |
| src_val | input | 64 | Source register value |
| imm | input | 32 | Immediate operand |
| offset | input | 16 | Signed branch offset in slots |
| pc | input | 32 | Current instruction slot |
| out_valid | output | 1 | Result present |
| br_taken | output | 1 | Branch taken |
| next_pc | output | 32 | Next instruction slot |
| call_req | output | 1 | Helper call requested |
| exit_req | output | 1 | Program exit requested |
| illegal_op | output | 1 | Opcode is not a legal jump |

## Verification
The signed and unsigned orderings run side by side on the same operand pair, and the sharpest case is a pair on which they disagree, such as a destination with its top bit set against a small positive value; in the narrow class this also coincides with operands whose upper words would give the opposite answer. The sweep pairs every opcode with operands chosen so that bit 63 and bit 31 differ in sign, and judges each result against a model that forms zero-extended and sign-extended views separately. Target wrap-around is provoked in the same vectors by program counters at both ends of the range with extreme offsets.

// File: rtl/brn_pkg.sv
package brn_pkg;

   localparam logic [2:0] CLS_WIDE   = 3'd5;
   localparam logic [2:0] CLS_NARROW = 3'd6;

   localparam logic [3:0] CC_ALWAYS = 4'h0;
   localparam logic [3:0] CC_EQ     = 4'h1;
   localparam logic [3:0] CC_UGT    = 4'h2;
   localparam logic [3:0] CC_UGE    = 4'h3;
   localparam logic [3:0] CC_SET    = 4'h4;
   localparam logic [3:0] CC_NE     = 4'h5;
   localparam logic [3:0] CC_SGT    = 4'h6;
   localparam logic [3:0] CC_SGE    = 4'h7;
   localparam logic [3:0] CC_CALL   = 4'h8;
   localparam logic [3:0] CC_EXIT   = 4'h9;
   localparam logic [3:0] CC_ULT    = 4'hA;
   localparam logic [3:0] CC_ULE    = 4'hB;
   localparam logic [3:0] CC_SLT    = 4'hC;
   localparam logic [3:0] CC_SLE    = 4'hD;

   typedef struct packed {
      logic       legal;
      logic       is_call;
      logic       is_exit;
      logic       narrow;
      logic       use_reg;
      logic [3:0] code;
   } brn_dec_t;

   typedef struct packed {
      logic eq;
      logic ugt;
      logic ult;
      logic sgt;
      logic slt;
      logic any_set;
   } brn_cmp_t;

endpackage

// File: rtl/brn_decode.sv
module brn_decode
   import brn_pkg::*;
(
   input  logic [7:0] opcode,
   output brn_dec_t   dec
);

   logic [2:0] cls;
   logic       jump_cls;
   logic       code_ok;

   always_comb begin
      cls         = opcode[2:0];
      jump_cls    = (cls == CLS_WIDE) || (cls == CLS_NARROW);
      dec.code    = opcode[7:4];
      dec.use_reg = opcode[3];
      dec.narrow  = (cls == CLS_NARROW);
      unique case (opcode[7:4])
         CC_ALWAYS, CC_EXIT:                 code_ok = !dec.narrow;
         CC_EQ, CC_UGT, CC_UGE, CC_SET,
         CC_NE, CC_SGT, CC_SGE, CC_CALL,
         CC_ULT, CC_ULE, CC_SLT, CC_SLE:     code_ok = 1'b1;
         default:                            code_ok = 1'b0;
      endcase
      dec.legal   = jump_cls && code_ok;
      dec.is_call = dec.legal && (opcode[7:4] == CC_CALL);
      dec.is_exit = dec.legal && (opcode[7:4] == CC_EXIT);
   end

endmodule

// File: rtl/brn_compare.sv
module brn_compare
   import brn_pkg::*;
#(
   parameter int W = 64
)(
   input  logic [W-1:0] lhs,
   input  logic [W-1:0] rhs,
   output brn_cmp_t     res
);

   generate
      if (W < 2) begin : g_bad_width
         $error("brn_compare: W must be at least 2");
      end
   endgenerate

   always_comb begin
      res.eq      = (lhs == rhs);
      res.ugt     = (lhs > rhs);
      res.ult     = (lhs < rhs);
      res.sgt     = ($signed(lhs) > $signed(rhs));
      res.slt     = ($signed(lhs) < $signed(rhs));
      res.any_set = |(lhs & rhs);
   end

   // R5 / R6: exactly one ordering relation holds for each interpretation
   always_comb begin
      assert_unsigned_trichotomy_R5: assert ($countones({res.eq, res.ugt, res.ult}) == 1);
      assert_signed_trichotomy_R6:   assert ($countones({res.eq, res.sgt, res.slt}) == 1);
   end

endmodule

// File: rtl/brn_target.sv
module brn_target #(
   parameter int PC_W  = 32,
   parameter int OFF_W = 16
)(
   input  logic [PC_W-1:0]  pc_cur,
   input  logic [OFF_W-1:0] off,
   input  logic             take,
   output logic [PC_W-1:0]  pc_nxt
);

   localparam int EXT_W = PC_W - OFF_W;

   logic [PC_W-1:0] off_ext;
   logic [PC_W-1:0] seq_pc;

   generate
      if (OFF_W > PC_W) begin : g_bad_off
         $error("brn_target: OFF_W must not exceed PC_W");
      end else if (OFF_W == PC_W) begin : g_off_full
         assign off_ext = off;
      end else begin : g_off_sext
         assign off_ext = {{EXT_W{off[OFF_W-1]}}, off};
      end
   endgenerate

   assign seq_pc = pc_cur + PC_W'(1);
   assign pc_nxt = take ? (seq_pc + off_ext) : seq_pc;

endmodule

// File: rtl/brn_eval_unit.sv
module brn_eval_unit
   import brn_pkg::*;
#(
   parameter int XLEN  = 64,
   parameter int LOW_W = 32,
   parameter int IMM_W = 32,
   parameter int OFF_W = 16,
   parameter int PC_W  = 32
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [7:0]       opcode,
   input  logic [XLEN-1:0]  dst_val,
   input  logic [XLEN-1:0]  src_val,
   input  logic [IMM_W-1:0] imm,
   input  logic [OFF_W-1:0] offset,
   input  logic [PC_W-1:0]  pc,
   output logic             out_valid,
   output logic             br_taken,
   output logic [PC_W-1:0]  next_pc,
   output logic             call_req,
   output logic             exit_req,
   output logic             illegal_op
);

   localparam int IMM_EXT_W = XLEN - IMM_W;

   generate
      if (LOW_W > XLEN) begin : g_bad_low
         $error("brn_eval_unit: LOW_W must not exceed XLEN");
      end
      if (IMM_W > XLEN) begin : g_bad_imm
         $error("brn_eval_unit: IMM_W must not exceed XLEN");
      end
      if (OFF_W > PC_W) begin : g_bad_off
         $error("brn_eval_unit: OFF_W must not exceed PC_W");
      end
   endgenerate

   brn_dec_t        dec;
   logic [XLEN-1:0] imm_ext;
   logic [XLEN-1:0] rhs_full;
   brn_cmp_t        cmp_w;
   brn_cmp_t        cmp_n;
   brn_cmp_t        cmp_sel;
   logic            cond;
   logic            take_c;
   logic [PC_W-1:0] npc_c;

   brn_decode u_dec (
      .opcode (opcode),
      .dec    (dec)
   );

   generate
      if (IMM_W == XLEN) begin : g_imm_full
         assign imm_ext = imm;
      end else begin : g_imm_sext
         assign imm_ext = {{IMM_EXT_W{imm[IMM_W-1]}}, imm};
      end
   endgenerate

   assign rhs_full = dec.use_reg ? src_val : imm_ext;

   brn_compare #(.W(XLEN)) u_cmp_wide (
      .lhs (dst_val),
      .rhs (rhs_full),
      .res (cmp_w)
   );

   generate
      if (LOW_W < XLEN) begin : g_narrow_cmp
         brn_compare #(.W(LOW_W)) u_cmp_narrow (
            .lhs (dst_val[LOW_W-1:0]),
            .rhs (rhs_full[LOW_W-1:0]),
            .res (cmp_n)
         );
      end else begin : g_narrow_shared
         assign cmp_n = cmp_w;
      end
   endgenerate

   assign cmp_sel = dec.narrow ? cmp_n : cmp_w;

   always_comb begin
      unique case (dec.code)
         CC_ALWAYS: cond = 1'b1;
         CC_EQ:     cond = cmp_sel.eq;
         CC_NE:     cond = !cmp_sel.eq;
         CC_SET:    cond = cmp_sel.any_set;
         CC_UGT:    cond = cmp_sel.ugt;
         CC_UGE:    cond = cmp_sel.ugt || cmp_sel.eq;
         CC_ULT:    cond = cmp_sel.ult;
         CC_ULE:    cond = cmp_sel.ult || cmp_sel.eq;
         CC_SGT:    cond = cmp_sel.sgt;
         CC_SGE:    cond = cmp_sel.sgt || cmp_sel.eq;
         CC_SLT:    cond = cmp_sel.slt;
         CC_SLE:    cond = cmp_sel.slt || cmp_sel.eq;
         default:   cond = 1'b0;
      endcase
      take_c = dec.legal && !dec.is_call && !dec.is_exit && cond;
   end

   brn_target #(.PC_W(PC_W), .OFF_W(OFF_W)) u_tgt (
      .pc_cur (pc),
      .off    (offset),
      .take   (take_c),
      .pc_nxt (npc_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         br_taken   <= 1'b0;
         call_req   <= 1'b0;
         exit_req   <= 1'b0;
         illegal_op <= 1'b0;
         next_pc    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            br_taken   <= take_c;
            call_req   <= dec.is_call;
            exit_req   <= dec.is_exit;
            illegal_op <= !dec.legal;
            next_pc    <= npc_c;
         end else begin
            br_taken   <= 1'b0;
            call_req   <= 1'b0;
            exit_req   <= 1'b0;
            illegal_op <= 1'b0;
         end
      end
   end

   assert_flags_exclusive_R13: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({br_taken, call_req, exit_req, illegal_op}));

   assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> !(br_taken || call_req || exit_req || illegal_op));

   assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_seq_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !br_taken) |-> (next_pc == PC_W'($past(pc) + PC_W'(1))));

   assert_narrow_always_illegal_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode[2:0] == CLS_NARROW && opcode[7:4] == CC_ALWAYS) |=> illegal_op);

   assert_narrow_exit_illegal_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode[2:0] == CLS_NARROW && opcode[7:4] == CC_EXIT) |=> (illegal_op && !exit_req));

   assert_call_not_taken_R9: assert property (@(posedge clk) disable iff (!rst_n)
      call_req |-> !br_taken);

endmodule

// File: tb/tb_brn_eval_unit.sv
`timescale 1ns/1ps
module tb_brn_eval_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  opcode = '0;
   logic [63:0] dst_val = '0;
   logic [63:0] src_val = '0;
   logic [31:0] imm = '0;
   logic [15:0] offset = '0;
   logic [31:0] pc = '0;
   logic        out_valid, br_taken, call_req, exit_req, illegal_op;
   logic [31:0] next_pc;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #10 clk = ~clk;

   brn_eval_unit dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
      .dst_val(dst_val), .src_val(src_val), .imm(imm), .offset(offset), .pc(pc),
      .out_valid(out_valid), .br_taken(br_taken), .next_pc(next_pc),
      .call_req(call_req), .exit_req(exit_req), .illegal_op(illegal_op)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h (op=%02h dst=%0h src=%0h imm=%0h pc=%0h off=%0h)",
                  tag, act, exp, opcode, dst_val, src_val, imm, pc, offset);
      end
   endtask

   function automatic string tag_of(input logic [3:0] cc);
      case (cc)
         4'h0:                      return "R8 always";
         4'h1, 4'h4, 4'h5:          return "R7 eq/ne/set";
         4'h2, 4'h3, 4'hA, 4'hB:    return "R5 unsigned";
         4'h6, 4'h7, 4'hC, 4'hD:    return "R6 signed";
         4'h8:                      return "R9 call";
         4'h9:                      return "R10 exit";
         default:                   return "R12 illegal code";
      endcase
   endfunction

   task automatic model(input logic [7:0] op, input logic [63:0] d, input logic [63:0] s,
                        input logic [31:0] im, input logic [15:0] off, input logic [31:0] p,
                        output logic t, output logic c, output logic e, output logic il,
                        output logic [31:0] np);
      logic [2:0]  cls;
      logic [3:0]  cc;
      logic        nar, lg, cond;
      logic [63:0] b, au, bu;
      longint      as_, bs_;
      cls = op[2:0];
      cc  = op[7:4];
      nar = (cls == 3'd6);
      b   = op[3] ? s : {{32{im[31]}}, im};
      if (nar) begin
         au  = {32'd0, d[31:0]};
         bu  = {32'd0, b[31:0]};
         as_ = longint'($signed(d[31:0]));
         bs_ = longint'($signed(b[31:0]));
      end else begin
         au  = d;
         bu  = b;
         as_ = $signed(d);
         bs_ = $signed(b);
      end
      lg = (cls == 3'd5 || cls == 3'd6) && (cc <= 4'hD) && !(nar && (cc == 4'h0 || cc == 4'h9));
      case (cc)
         4'h0: cond = 1;
         4'h1: cond = (au == bu);
         4'h2: cond = (au > bu);
         4'h3: cond = (au >= bu);
         4'h4: cond = ((au & bu) != 0);
         4'h5: cond = (au != bu);
         4'h6: cond = (as_ > bs_);
         4'h7: cond = (as_ >= bs_);
         4'hA: cond = (au < bu);
         4'hB: cond = (au <= bu);
         4'hC: cond = (as_ < bs_);
         4'hD: cond = (as_ <= bs_);
         default: cond = 0;
      endcase
      c  = lg && cc == 4'h8;
      e  = lg && cc == 4'h9;
      il = !lg;
      t  = lg && !c && !e && cond;
      np = p + 32'd1 + (t ? {{16{off[15]}}, off} : 32'd0);
   endtask

   task automatic apply_and_check(input logic [7:0] op, input logic [63:0] d, input logic [63:0] s,
                                  input logic [31:0] im, input logic [15:0] off, input logic [31:0] p,
                                  input string extra);
      logic t, c, e, il;
      logic [31:0] np;
      opcode = op; dst_val = d; src_val = s; imm = im; offset = off; pc = p; in_valid = 1'b1;
      model(op, d, s, im, off, p, t, c, e, il, np);
      @(negedge clk);
      chk({"R2 out_valid ", extra}, out_valid, 1);
      chk({tag_of(op[7:4]), " taken ", extra}, br_taken, t);
      chk({"R11 next_pc ", extra}, next_pc, np);
      chk({"R9 call_req ", extra}, call_req, c);
      chk({"R10 exit_req ", extra}, exit_req, e);
      chk({"R12 illegal_op ", extra}, illegal_op, il);
      chk({"R13 exclusive ", extra}, $countones({br_taken, call_req, exit_req, illegal_op}) <= 1, 1);
   endtask

   logic [63:0] vals [6];
   logic [31:0] pcs  [4];
   logic [15:0] offs [5];

   initial begin
      vals[0] = 64'h0;
      vals[1] = 64'h1;
      vals[2] = 64'hFFFF_FFFF_FFFF_FFFF;
      vals[3] = 64'h8000_0000_0000_0000;
      vals[4] = 64'h0000_0001_8000_0000;
      vals[5] = 64'h7FFF_FFFF_0000_0001;
      pcs[0] = 32'h0; pcs[1] = 32'hFFFF_FFFF; pcs[2] = 32'h0000_1234; pcs[3] = 32'h7FFF_FFF0;
      offs[0] = 16'h0; offs[1] = 16'h0005; offs[2] = 16'hFFFF; offs[3] = 16'h8000; offs[4] = 16'h7FFF;

      // R1: reset state
      repeat (2) @(negedge clk);
      chk("R1 out_valid", out_valid, 0);
      chk("R1 br_taken", br_taken, 0);
      chk("R1 next_pc", next_pc, 0);
      chk("R1 call_req", call_req, 0);
      chk("R1 exit_req", exit_req, 0);
      chk("R1 illegal_op", illegal_op, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // Sweep every opcode over operand pairs with sign boundaries at bit 31 and 63
      for (int op = 0; op < 256; op++)
         for (int i = 0; i < 6; i++)
            for (int j = 0; j < 6; j++)
               apply_and_check(8'(op), vals[i], vals[j], vals[j][31:0],
                               offs[(op + i) % 5], pcs[(i + j) % 4], "sweep");

      // R3: low words equal, upper words differ -> narrow eq taken, wide eq not
      apply_and_check(8'h1E, 64'hAAAA_0000_1234_5678, 64'h5555_0000_1234_5678, 32'h0, 16'h0010, 32'h100, "R3 narrow eq");
      chk("R3 narrow eq taken", br_taken, 1);
      apply_and_check(8'h1D, 64'hAAAA_0000_1234_5678, 64'h5555_0000_1234_5678, 32'h0, 16'h0010, 32'h100, "R3 wide eq");
      chk("R3 wide eq not taken", br_taken, 0);
      // R4: negative immediate sign-extended in wide class
      apply_and_check(8'h15, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 32'hFFFF_FFFF, 16'h0002, 32'h40, "R4 imm sext");
      chk("R4 imm sext taken", br_taken, 1);
      chk("R4 imm sext target", next_pc, 32'h43);
      // R11: wrap at top of range
      apply_and_check(8'h05, 64'h0, 64'h0, 32'h0, 16'h0001, 32'hFFFF_FFFF, "R11 wrap");
      chk("R11 wrap target", next_pc, 32'h1);

      // R2: idle cycle clears flags
      in_valid = 1'b0;
      @(negedge clk);
      chk("R2 idle out_valid", out_valid, 0);
      chk("R2 idle flags", {br_taken, call_req, exit_req, illegal_op}, 0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule